// File: doc/BRIEF.md
# Dual Overlapping Serial Sequence Detector

This block watches a serial bit stream, taking one bit per rising clock edge, and raises a one-cycle pulse when the most recent bits end either of two fixed target sequences. The first sequence is 1,1,0,0,1 and the second is 1,1,0,1, where the leftmost bit arrives first.

Occurrences may overlap, within one pattern or across the two. The bits that complete one match stay available as the start of the next match of either pattern. One small state machine follows both patterns at once. Its state is held in flip-flops, and the output is decoded from the state alone.

A synchronous reset clears any partial match. Bits sampled before a reset never contribute to a later match.

Top module: `seqdet_dual`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to idle, and `detect` is 0 in the cycle after that edge.
- R2: When the last five bits sampled since reset are 1,1,0,0,1 (oldest first), `detect` is 1.
- R3: When the last four bits sampled since reset are 1,1,0,1 (oldest first), `detect` is 1.
- R4: `detect` is registered (Moore). It rises in the cycle after the edge that samples the final matching bit, and it is 0 before that edge.
- R5: `detect` is never 1 in two consecutive cycles.
- R6: Overlap within one pattern counts. The stream 1101101 gives two pulses, and the stream 110011001 gives two pulses.
- R7: Overlap across the two patterns counts. The stream 11001101 gives two pulses, and the stream 11011001 gives two pulses.
- R8: `detect` is 0 in every cycle where neither R2 nor R3 applies, for example after 11000 or after a run of ones.
- R9: Bits sampled before a reset do not complete a match. The stream 110, then a reset, then 1 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one stream bit per edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| detect | output | 1 | One-cycle pulse when either target sequence completes |

## Verification
Every 12-bit stream is applied from a fresh reset, and the output is compared each cycle against a sliding window of the bits sampled since reset. This sweep separates five-bit matches from four-bit matches from near misses, and it covers every overlap that fits in twelve bits. Directed streams then count pulses for same-pattern and cross-pattern overlap. Further streams check the one-cycle rise timing, a reset applied in the middle of a prefix, and a reset that lands on the edge of a completing bit.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int STATE_W = 3;

  // Each state records the longest suffix of the stream that is a prefix of a pattern.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE     = 3'd0,  // no useful suffix
    ST_ONE      = 3'd1,  // "1"
    ST_TWO      = 3'd2,  // "11"
    ST_TWO_Z    = 3'd3,  // "110"
    ST_TWO_ZZ   = 3'd4,  // "1100"
    ST_MATCH    = 3'd5   // a pattern just ended; suffix "1"
  } det_state_t;

  function automatic det_state_t step_state(det_state_t s, logic b);
    det_state_t n;
    case (s)
      ST_IDLE:   n = b ? ST_ONE   : ST_IDLE;
      ST_ONE:    n = b ? ST_TWO   : ST_IDLE;
      ST_TWO:    n = b ? ST_TWO   : ST_TWO_Z;
      ST_TWO_Z:  n = b ? ST_MATCH : ST_TWO_ZZ;
      ST_TWO_ZZ: n = b ? ST_MATCH : ST_IDLE;
      ST_MATCH:  n = b ? ST_TWO   : ST_IDLE;
      default:   n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic state_hits(det_state_t s);
    return (s == ST_MATCH);
  endfunction

  function automatic logic state_legal(det_state_t s);
    return (s == ST_IDLE) || (s == ST_ONE) || (s == ST_TWO) ||
           (s == ST_TWO_Z) || (s == ST_TWO_ZZ) || (s == ST_MATCH);
  endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  det_state_t cur,
  input  logic       bit_in,
  output det_state_t nxt,
  output logic       long_done,
  output logic       short_done
);

  assign nxt        = step_state(cur, bit_in);
  assign long_done  = (cur == ST_TWO_ZZ) && bit_in;
  assign short_done = (cur == ST_TWO_Z) && bit_in;

endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  det_state_t nxt,
  output det_state_t cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end

  // R1
  property reset_idle_chk_p;
    @(posedge clk) rst |=> (cur == ST_IDLE);
  endproperty
  reset_idle_chk: assert property (reset_idle_chk_p);

  // R8
  property state_legal_chk_p;
    @(posedge clk) disable iff (rst) state_legal(nxt) |=> state_legal(cur);
  endproperty
  state_legal_chk: assert property (state_legal_chk_p);

endmodule

// File: rtl/seqdet_out_decode.sv
module seqdet_out_decode
  import seqdet_pkg::*;
(
  input  det_state_t cur,
  output logic       hit
);

  assign hit = state_hits(cur);

endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic detect
);

  det_state_t state_q;
  det_state_t state_d;
  logic       long_done;
  logic       short_done;

  seqdet_next u_next (
    .cur        (state_q),
    .bit_in     (din),
    .nxt        (state_d),
    .long_done  (long_done),
    .short_done (short_done)
  );

  seqdet_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (state_d),
    .cur (state_q)
  );

  seqdet_out_decode u_out (
    .cur (state_q),
    .hit (detect)
  );

  // R4
  property hit_follows_chk_p;
    @(posedge clk) disable iff (rst) (long_done || short_done) |=> detect;
  endproperty
  hit_follows_chk: assert property (hit_follows_chk_p);

  // R5
  property single_pulse_chk_p;
    @(posedge clk) disable iff (rst) detect |=> !detect;
  endproperty
  single_pulse_chk: assert property (single_pulse_chk_p);

  // R1
  property reset_quiet_chk_p;
    @(posedge clk) rst |=> !detect;
  endproperty
  reset_quiet_chk: assert property (reset_quiet_chk_p);

  // R8
  property last_bit_one_chk_p;
    @(posedge clk) disable iff (rst) detect |-> $past(din);
  endproperty
  last_bit_one_chk: assert property (last_bit_one_chk_p);

endmodule

// File: tb/tb_seqdet_dual.sv
`timescale 1ns/1ps
module tb_seqdet_dual;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic detect;

  int   n_cmp = 0;
  int   n_bad = 0;
  logic [4:0] hist = '0;
  logic prev_det = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  seqdet_dual dut (.clk(clk), .rst(rst), .din(din), .detect(detect));

  task automatic check(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: detect=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model(logic [4:0] h);
    return (h == 5'b11001) || (h[3:0] == 4'b1101);
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", detect, 1'b0);
    rst = 1'b0;
    hist = '0;
    prev_det = 1'b0;
  endtask

  task automatic feed(logic b, output logic got);
    logic exp;
    din = b;
    @(posedge clk);
    hist = {hist[3:0], b};
    @(negedge clk);
    exp = model(hist);
    if (hist == 5'b11001)         check("R2", detect, exp);
    else if (hist[3:0] == 4'b1101) check("R3", detect, exp);
    else                           check("R8", detect, exp);
    if (detect === 1'b1) check("R5", prev_det, 1'b0);
    prev_det = detect;
    got = detect;
  endtask

  task automatic run_count(logic [15:0] bits, int len, output int hits);
    logic g;
    hits = 0;
    do_reset();
    for (int i = len - 1; i >= 0; i--) begin
      feed(bits[i], g);
      if (g === 1'b1) hits++;
    end
  endtask

  task automatic count_check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: pulses=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    logic g;
    int   h;
    @(negedge clk);
    do_reset();

    // R2 R3 R8: every 12-bit stream from reset
    for (int v = 0; v < 4096; v++) begin
      do_reset();
      for (int i = 11; i >= 0; i--) feed(v[i], g);
    end

    // R6: overlap inside one pattern
    run_count(16'b1101101, 7, h);       count_check("R6", h, 2);
    run_count(16'b110011001, 9, h);     count_check("R6", h, 2);
    // R7: overlap across patterns
    run_count(16'b11001101, 8, h);      count_check("R7", h, 2);
    run_count(16'b11011001, 8, h);      count_check("R7", h, 2);
    // R8: all ones and 11000 give none
    run_count(16'hFFFF, 16, h);         count_check("R8", h, 0);
    run_count(16'b110001, 6, h);        count_check("R8", h, 0);

    // R4: low before the completing edge, high right after it
    do_reset();
    feed(1'b1, g); feed(1'b1, g); feed(1'b0, g);
    din = 1'b1;
    check("R4", detect, 1'b0);
    @(posedge clk);
    hist = {hist[3:0], 1'b1};
    @(negedge clk);
    check("R4", detect, 1'b1);
    prev_det = detect;
    feed(1'b0, g);
    check("R5", g, 1'b0);

    // R9: prefix before reset does not complete
    do_reset();
    feed(1'b1, g); feed(1'b1, g); feed(1'b0, g);
    do_reset();
    feed(1'b1, g);
    check("R9", g, 1'b0);
    do_reset();
    feed(1'b1, g); feed(1'b1, g); feed(1'b0, g); feed(1'b0, g);
    do_reset();
    feed(1'b1, g);
    check("R9", g, 1'b0);

    // R1: reset on the edge that would complete a match
    do_reset();
    feed(1'b1, g); feed(1'b1, g); feed(1'b0, g);
    din = 1'b1;
    do_reset();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule